// File: doc/BRIEF.md
# Message Identifier Acceptance Filter Bank

This block sits between the frame receiver and the receive FIFO of a message controller and decides whether each received frame is kept. Every frame's 32-bit identifier word is compared against a bank of mask/ID filter pairs. A filter hits when the identifier and the filter's stored ID agree on every bit that the filter's mask selects. The frame is kept when at least one enabled filter hits. When no filter is enabled, or the bank is built with no filters, every frame is kept.

Software programs the bank through a flat register port with one write strobe and a combinational read. The receiver presents one identifier per cycle with a valid strobe. One cycle later it gets a registered verdict together with a one-cycle valid pulse. The number of filters is a build parameter from 0 to 4.

Top module: `acf_bank`

## Requirements
- R1: After reset every register reads 0, `verdict_valid_o` is 0, and the bank accepts every frame.
- R2: Register map: address 0 is the enable register, with bit i enabling filter i. Address 2i+1 is the mask of filter i and address 2i+2 is its ID. A value written to a mask or ID address reads back in full on `reg_rdata_o` in the cycle after the write, whether or not the filter is enabled.
- R3: Enable bits at positions `NUM_FILT` and above read as 0 and are discarded on write. Addresses above 2*`NUM_FILT` read 0, and writes to them change no register and no verdict.
- R4: A filter hits when (identifier AND mask) equals (stored ID AND mask) on all 32 bits. Bits where the mask is 0 never affect the hit.
- R5: The verdict is the OR of the hits of the enabled filters. A disabled filter never causes acceptance.
- R6: When every enable bit is 0, every identifier is accepted, whatever the masks and IDs hold.
- R7: Each cycle with `id_valid_i` high produces `verdict_valid_o` high on the next cycle, with the verdict on `accept_o`. Identifiers may arrive back to back. `verdict_valid_o` is low in every other cycle, and `accept_o` is 0 whenever `verdict_valid_o` is 0.
- R8: With `NUM_FILT` = 0, every identifier is accepted, every register address reads 0, and writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | ID_W | Register write data |
| reg_rdata_o | output | ID_W | Read data for `reg_addr_i`, combinational |
| id_valid_i | input | 1 | An identifier is presented this cycle |
| id_i | input | ID_W | Identifier word of the received frame |
| verdict_valid_o | output | 1 | Verdict valid, one cycle after `id_valid_i` |
| accept_o | output | 1 | 1 = store the frame in the receive FIFO |

## Verification
A read is combinational, so the bench sets the address on a falling edge and compares the read data a few nanoseconds later. It does this only after the rising edge that completes the write. An identifier driven on a falling edge is registered on the next rising edge, so the verdict and its valid pulse are sampled at the following falling edge. The falling edge after that must show the valid pulse low again. For back-to-back identifiers, each falling edge holds the verdict of the identifier presented one cycle earlier. Register writes are never issued in the same cycle as an identifier, so every expected verdict comes from a settled filter state.

// File: rtl/acf_pkg.sv
package acf_pkg;
  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_ENA,
    SEL_MASK,
    SEL_ID
  } acf_sel_e;
endpackage

// File: rtl/acf_regs.sv
module acf_regs
  import acf_pkg::*;
#(
  parameter int NF     = 4,
  parameter int W      = 32,
  parameter int AW     = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [W-1:0]          wdata_i,
  output logic [W-1:0]          rdata_o,
  output logic [NF-1:0][W-1:0]  mask_o,
  output logic [NF-1:0][W-1:0]  fid_o,
  output logic [NF-1:0]         en_o
);
  localparam logic [AW-1:0] TOP_ADDR = AW'(2 * NF);

  acf_sel_e             sel;
  logic [AW-1:0]        idx;
  logic [NF-1:0][W-1:0] mask_q, fid_q;
  logic [NF-1:0]        en_q;

  // odd addresses hold masks, even nonzero addresses hold IDs
  always_comb begin
    sel = SEL_NONE;
    idx = (addr_i - AW'(1)) >> 1;
    if (addr_i == '0)            sel = SEL_ENA;
    else if (addr_i <= TOP_ADDR) sel = addr_i[0] ? SEL_MASK : SEL_ID;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      fid_q  <= '0;
      en_q   <= '0;
    end else if (we_i) begin
      if (sel == SEL_ENA) en_q <= wdata_i[NF-1:0];
      for (int i = 0; i < NF; i++) begin
        if (idx == AW'(i)) begin
          if (sel == SEL_MASK) mask_q[i] <= wdata_i;
          if (sel == SEL_ID)   fid_q[i]  <= wdata_i;
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel == SEL_ENA) rdata_o = W'(en_q);
    for (int i = 0; i < NF; i++) begin
      if (idx == AW'(i)) begin
        if (sel == SEL_MASK) rdata_o = mask_q[i];
        if (sel == SEL_ID)   rdata_o = fid_q[i];
      end
    end
  end

  assign mask_o = mask_q;
  assign fid_o  = fid_q;
  assign en_o   = en_q;

  // R3
  ena_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == '0) |=> (en_q == $past(wdata_i[NF-1:0])));

  // R3
  oob_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i > TOP_ADDR) |=> ($stable(mask_q) && $stable(fid_q) && $stable(en_q)));
endmodule

// File: rtl/acf_match.sv
module acf_match #(
  parameter int W = 32
) (
  input  logic [W-1:0] cand_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] fid_i,
  input  logic         en_i,
  output logic         hit_o
);
  assign hit_o = en_i && (((cand_i ^ fid_i) & mask_i) == '0);
endmodule

// File: rtl/acf_bank.sv
module acf_bank #(
  parameter int NUM_FILT = 4,
  parameter int ID_W     = 32,
  parameter int ADDR_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [ID_W-1:0]   reg_wdata_i,
  output logic [ID_W-1:0]   reg_rdata_o,
  input  logic              id_valid_i,
  input  logic [ID_W-1:0]   id_i,
  output logic              verdict_valid_o,
  output logic              accept_o
);
  logic pass;
  logic vld_q, acc_q;

  if (NUM_FILT > 0) begin : g_bank
    logic [NUM_FILT-1:0][ID_W-1:0] mask, fid;
    logic [NUM_FILT-1:0]           en, hit;

    acf_regs #(.NF(NUM_FILT), .W(ID_W), .AW(ADDR_W)) u_regs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (reg_we_i),
      .addr_i  (reg_addr_i),
      .wdata_i (reg_wdata_i),
      .rdata_o (reg_rdata_o),
      .mask_o  (mask),
      .fid_o   (fid),
      .en_o    (en)
    );

    for (genvar i = 0; i < NUM_FILT; i++) begin : g_filt
      acf_match #(.W(ID_W)) u_match (
        .cand_i (id_i),
        .mask_i (mask[i]),
        .fid_i  (fid[i]),
        .en_i   (en[i]),
        .hit_o  (hit[i])
      );

      // R4
      filt_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (id_valid_i && en[i] && ((id_i & mask[i]) == (fid[i] & mask[i]))) |=> accept_o);
    end

    // no enabled filter means nothing to reject against
    assign pass = (en == '0) || (|hit);

    // R6
    none_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (id_valid_i && en == '0) |=> accept_o);
  end else begin : g_empty
    logic unused_reg;
    assign unused_reg  = ^{reg_we_i, reg_addr_i, reg_wdata_i};
    assign reg_rdata_o = '0;
    assign pass        = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      acc_q <= 1'b0;
    end else begin
      vld_q <= id_valid_i;
      acc_q <= id_valid_i && pass;
    end
  end

  assign verdict_valid_o = vld_q;
  assign accept_o        = acc_q;

  // R7
  verdict_due_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_valid_i |=> verdict_valid_o);

  // R7
  no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_valid_i |=> !verdict_valid_o);

  // R7
  accept_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !verdict_valid_o |-> !accept_o);
endmodule

// File: tb/acf_bank_test.sv
`timescale 1ns/1ps
module acf_bank_test;
  localparam int NF = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        vld = 1'b0;
  logic [31:0] cand = '0;
  logic [31:0] rdata, rdata0;
  logic        vout, acc, vout0, acc0;

  int total = 0, bad = 0, cyc = 0;

  logic [31:0] m_mask [NF];
  logic [31:0] m_fid  [NF];
  logic [NF-1:0] m_en;

  always #10 clk = ~clk;

  acf_bank #(.NUM_FILT(NF)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .id_valid_i(vld), .id_i(cand),
    .verdict_valid_o(vout), .accept_o(acc));

  acf_bank #(.NUM_FILT(0)) uut0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata0), .id_valid_i(vld), .id_i(cand),
    .verdict_valid_o(vout0), .accept_o(acc0));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit exp_accept(input logic [31:0] c);
    bit any = 0, hit = 0;
    for (int i = 0; i < NF; i++)
      if (m_en[i]) begin
        any = 1;
        if (((c ^ m_fid[i]) & m_mask[i]) == '0) hit = 1;
      end
    return !any || hit;
  endfunction

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    if (a == 0) return 32'(m_en);
    if (a <= 2 * NF) return a[0] ? m_mask[(a - 1) >> 1] : m_fid[(a - 1) >> 1];
    return '0;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
    if (a == 0) m_en = d[NF-1:0];
    else if (a <= 2 * NF) begin
      if (a[0]) m_mask[(a - 1) >> 1] = d;
      else      m_fid[(a - 1) >> 1]  = d;
    end
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    @(negedge clk);
    addr = a;
    #2;
    chk(rdata == exp_read(a), tag, rdata, exp_read(a));
    chk(rdata0 == '0, "R8 read", rdata0, 32'd0);
  endtask

  task automatic present(input logic [31:0] c, input string tag);
    @(negedge clk);
    cand = c; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
    chk(vout == 1'b1, "R7 valid", 32'(vout), 32'd1);
    chk(acc == exp_accept(c), tag, 32'(acc), 32'(exp_accept(c)));
    chk(vout0 && acc0, "R8 accept", 32'({vout0, acc0}), 32'd3);
    @(negedge clk);
    chk(!vout && !acc, "R7 idle", 32'({vout, acc}), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NF; i++) begin m_mask[i] = '0; m_fid[i] = '0; end
    m_en = '0;
    #35;
    chk(!vout && !vout0, "R1 valid at reset", 32'({vout, vout0}), 32'd0);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 16; a++) rd(4'(a), "R1 reset read");
    present(32'hDEAD_BEEF, "R1 accept after reset");

    // R2 readback with filters disabled; R6 still accept all
    wr(1, 32'h0000_FFFF); wr(2, 32'h0000_1234);
    wr(7, 32'hFFFF_FFFF); wr(8, 32'hA5A5_5A5A);
    for (int a = 1; a <= 8; a++) rd(4'(a), "R2 readback");
    present(32'h0000_0000, "R6 all disabled");

    // R3 enable bits above count, out-of-range addresses
    wr(0, 32'hFFFF_FFF0);
    rd(0, "R3 enable high bits");
    present(32'h0000_0000, "R6 zero enable");
    wr(12, 32'hFFFF_FFFF); wr(15, 32'h1);
    for (int a = 9; a < 16; a++) rd(4'(a), "R3 oob read");
    rd(0, "R3 oob no side effect");
    present(32'h1, "R3 verdict after oob write");

    // R4 masked compare on filter 0
    wr(0, 32'h1);
    present(32'hFFFF_1234, "R4 masked match");
    present(32'h0000_1235, "R4 mismatch");
    wr(1, 32'h0);
    present(32'h1357_9BDF, "R4 zero mask matches all");

    // R5 OR across filters, disabled filter ignored
    wr(1, 32'hFFFF_FFFF); wr(0, 32'h8);
    present(32'hA5A5_5A5A, "R5 filter3 hit");
    present(32'h0000_1234, "R5 disabled filter0");
    wr(0, 32'h9);
    present(32'h0000_1234, "R5 filter0 hit");
    present(32'h0000_1111, "R5 no hit");

    // R7 back to back
    @(negedge clk); cand = 32'hA5A5_5A5A; vld = 1'b1;
    @(negedge clk);
    chk(vout && acc == exp_accept(32'hA5A5_5A5A), "R7 b2b first", 32'({vout, acc}), 32'd3);
    cand = 32'h0000_2222;
    @(negedge clk); vld = 1'b0;
    chk(vout && acc == exp_accept(32'h0000_2222), "R7 b2b second", 32'({vout, acc}), 32'd2);
    @(negedge clk);
    chk(!vout, "R7 b2b end", 32'(vout), 32'd0);

    // random configurations
    for (int it = 0; it < 120; it++) begin
      for (int i = 0; i < NF; i++) begin
        wr(4'(2 * i + 1), $urandom() & $urandom());
        wr(4'(2 * i + 2), $urandom());
      end
      wr(0, $urandom());
      rd(4'($urandom_range(0, 15)), "R2 random read");
      for (int k = 0; k < 6; k++) begin
        int f = $urandom_range(0, NF - 1);
        logic [31:0] c = $urandom_range(0, 1) ? (m_fid[f] ^ ($urandom() & ~m_mask[f])) : $urandom();
        present(c, "R5 random verdict");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule